// File: doc/BRIEF.md
# Coprocessor Bus Slave Ready Generator

This block is the bus-cycle sequencer for a coprocessor that answers as a slave on a host processor's local bus. The host opens a cycle by strobing the address with the coprocessor selected. From the next clock the block sits in a ready-sensitive phase. It stays there until the system ready input is sampled active, then goes back to idle.

While a cycle runs, the block raises its own one-clock ready output at a fixed point. That point is the first ready-sensitive clock for an ordinary write. It is the second for a read or for a slow (state-restore) write. The ready output can feed the host's ready logic directly, be OR-ed with other devices, or feed a wait-state generator. The cycle itself is ended only by the system ready input. In read cycles the 32-bit data word is driven with its output enable high for the whole ready-sensitive phase. The enable drops when the block returns to idle.

Top module: `cop_bus_ready_gen`

## Requirements
- R1: After reset the block is idle with `rdy_o` and `dout_oe_o` low and `dout_o` zero.
- R2: A cycle starts only when `ads_i` and `cs_i` are both high at a rising edge in idle. The clock after that edge is the first ready-sensitive clock. A strobe with `cs_i` low starts nothing.
- R3: For a write (`wr_i`=1) with `slow_wr_i`=0, `rdy_o` is high for exactly one clock, the first ready-sensitive clock.
- R4: For a read (`wr_i`=0), or a write with `slow_wr_i`=1, `rdy_o` is high for exactly one clock, the second ready-sensitive clock.
- R5: The position of the `rdy_o` pulse does not depend on how many wait states `rdy_i` adds. `rdy_o` is never high in two consecutive clocks.
- R6: In a read cycle `dout_oe_o` is high and `dout_o` equals `rdata_i` in every ready-sensitive clock. In write cycles and in idle, `dout_oe_o` is low and `dout_o` is zero.
- R7: `rdy_i` sampled high in a ready-sensitive clock returns the block to idle at that edge, with `dout_oe_o` low in the next clock.
- R8: If a read or slow-write cycle ends in its first ready-sensitive clock, no `rdy_o` pulse is produced for it.
- R9: `wr_i` and `slow_wr_i` are latched at the start edge. Changes to them during the cycle have no effect on that cycle.
- R10: A new cycle may start in the first idle clock after a cycle ends. It behaves like any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ads_i | input | 1 | Address strobe from the host, active high |
| cs_i | input | 1 | Coprocessor select, active high |
| wr_i | input | 1 | 1 = write cycle, 0 = read cycle |
| slow_wr_i | input | 1 | Write is a state-restore transfer that needs a wait state |
| rdy_i | input | 1 | System ready, ends the cycle |
| rdata_i | input | 32 | Read data word |
| rdy_o | output | 1 | One-clock ready pulse generated by the block |
| dout_o | output | 32 | Data-bus output value |
| dout_oe_o | output | 1 | Data-bus output enable |

## Verification
A wrong phase count shows up as a `rdy_o` pulse one clock early or late. It is visible in the very cycle affected, so the bench compares `rdy_o` against an expected pulse position in every clock. A stuck or lost state shows up in the clock after the `rdy_i` edge: either the data enable stays high, or the next strobe is not accepted. Latching faults show up only when `wr_i` or `slow_wr_i` toggle mid-cycle, so the stimulus toggles them on purpose.

// File: rtl/cop_bus_pkg.sv
package cop_bus_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RS   = 1'b1
  } bus_st_e;
endpackage

// File: rtl/cop_bus_fsm.sv
module cop_bus_fsm
  import cop_bus_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ads_i,
  input  logic             cs_i,
  input  logic             wr_i,
  input  logic             slow_wr_i,
  input  logic             rdy_i,
  output bus_st_e          st_o,
  output logic [CNT_W-1:0] rs_cnt_o,
  output logic             wr_q_o,
  output logic             slow_q_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  bus_st_e st_q;
  logic [CNT_W-1:0] cnt_q;
  logic start;

  assign start = (st_q == ST_IDLE) && ads_i && cs_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      wr_q_o   <= 1'b0;
      slow_q_o <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q     <= ST_RS;
          cnt_q    <= CNT_W'(1);
          wr_q_o   <= wr_i;
          slow_q_o <= slow_wr_i;
        end
        ST_RS: begin
          if (rdy_i) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o     = st_q;
  assign rs_cnt_o = cnt_q;

  // R7
  end_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RS && rdy_i) |=> st_q == ST_IDLE);
  // R2
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !(ads_i && cs_i)) |=> st_q == ST_IDLE);
endmodule

// File: rtl/cop_ready_timer.sv
module cop_ready_timer
  import cop_bus_pkg::*;
#(
  parameter int CNT_W    = 2,
  parameter int FAST_POS = 1,
  parameter int SLOW_POS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bus_st_e          st_i,
  input  logic [CNT_W-1:0] rs_cnt_i,
  input  logic             wr_q_i,
  input  logic             slow_q_i,
  output logic             rdy_o
);
  localparam logic [CNT_W-1:0] FAST_C = CNT_W'(FAST_POS);
  localparam logic [CNT_W-1:0] SLOW_C = CNT_W'(SLOW_POS);

  logic fast;
  assign fast  = wr_q_i && !slow_q_i;
  assign rdy_o = (st_i == ST_RS) && (rs_cnt_i == (fast ? FAST_C : SLOW_C));

  // R5
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) |-> !rdy_o);
endmodule

// File: rtl/cop_data_drv.sv
module cop_data_drv
  import cop_bus_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bus_st_e       st_i,
  input  logic          wr_q_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] dout_o,
  output logic          dout_oe_o
);
  assign dout_oe_o = (st_i == ST_RS) && !wr_q_i;
  assign dout_o    = dout_oe_o ? rdata_i : '0;

  // R6
  oe_in_rs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_oe_o |-> st_i == ST_RS);
endmodule

// File: rtl/cop_bus_ready_gen.sv
module cop_bus_ready_gen
  import cop_bus_pkg::*;
#(
  parameter int DW       = 32,
  parameter int CNT_W    = 2,
  parameter int FAST_POS = 1,
  parameter int SLOW_POS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ads_i,
  input  logic          cs_i,
  input  logic          wr_i,
  input  logic          slow_wr_i,
  input  logic          rdy_i,
  input  logic [DW-1:0] rdata_i,
  output logic          rdy_o,
  output logic [DW-1:0] dout_o,
  output logic          dout_oe_o
);
  bus_st_e          st;
  logic [CNT_W-1:0] rs_cnt;
  logic             wr_q, slow_q;

  cop_bus_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni, .ads_i, .cs_i, .wr_i, .slow_wr_i, .rdy_i,
    .st_o(st), .rs_cnt_o(rs_cnt), .wr_q_o(wr_q), .slow_q_o(slow_q)
  );

  cop_ready_timer #(.CNT_W(CNT_W), .FAST_POS(FAST_POS), .SLOW_POS(SLOW_POS)) u_tmr (
    .clk_i, .rst_ni, .st_i(st), .rs_cnt_i(rs_cnt), .wr_q_i(wr_q),
    .slow_q_i(slow_q), .rdy_o
  );

  cop_data_drv #(.DW(DW)) u_drv (
    .clk_i, .rst_ni, .st_i(st), .wr_q_i(wr_q), .rdata_i, .dout_o, .dout_oe_o
  );

  // R4
  read_no_early_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dout_oe_o) |-> !rdy_o);
  // R7
  oe_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_oe_o && rdy_i) |=> !dout_oe_o);
endmodule

// File: tb/cop_bus_ready_gen_tb_top.sv
module cop_bus_ready_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  typedef struct {
    logic          rdy;
    logic          oe;
    logic [DW-1:0] dout;
    string         req;
  } exp_t;

  logic clk = 0, rst_ni = 0;
  logic ads = 0, cs = 0, wr = 0, slow = 0, rdy_in = 0;
  logic [DW-1:0] rdata = '0;
  logic rdy_out, oe;
  logic [DW-1:0] dout;
  int checks = 0, errors = 0;
  exp_t q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cop_bus_ready_gen dut_i (
    .clk_i(clk), .rst_ni, .ads_i(ads), .cs_i(cs), .wr_i(wr), .slow_wr_i(slow),
    .rdy_i(rdy_in), .rdata_i(rdata), .rdy_o(rdy_out), .dout_o(dout), .dout_oe_o(oe)
  );

  task automatic push(input logic r, input logic o, input string req);
    exp_t e;
    e.rdy = r; e.oe = o; e.dout = o ? rdata : '0; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle_clk(input string req);
    @(negedge clk);
    ads = 0; cs = 0; rdy_in = 0; rdata = $urandom;
    push(0, 0, req);
  endtask

  // one bus cycle with n ready-sensitive clocks; toggle flips wr/slow mid-cycle
  task automatic bus_cycle(input logic w, input logic s, input int n,
                           input bit toggle, input string req);
    int tgt;
    tgt = (w && !s) ? 1 : 2;
    @(negedge clk);
    ads = 1; cs = 1; wr = w; slow = s; rdy_in = 0; rdata = $urandom;
    push(0, 0, req);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      ads = 0; cs = 0; rdata = $urandom;
      if (toggle) begin wr = ~wr; slow = ~slow; end
      rdy_in = (k == n);
      push(k == tgt, !w, req);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (rdy_out !== e.rdy || oe !== e.oe || dout !== e.dout) begin
          errors++;
          $display("FAIL %s: rdy=%b oe=%b dout=%h expected rdy=%b oe=%b dout=%h",
                   e.req, rdy_out, oe, dout, e.rdy, e.oe, e.dout);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (2) @(negedge clk);
    push(0, 0, "R1 reset");
    rst_ni = 1;
    idle_clk("R1 idle");
    // strobe without select: nothing starts
    @(negedge clk);
    ads = 1; cs = 0; wr = 1; rdata = $urandom;
    push(0, 0, "R2 no cs");
    idle_clk("R2 no cs");
    idle_clk("R2 no cs");
    bus_cycle(1, 0, 1, 0, "R3 fast write 0ws");
    bus_cycle(1, 0, 4, 0, "R3 fast write 3ws");
    bus_cycle(0, 0, 2, 0, "R4 read min");
    bus_cycle(0, 0, 5, 0, "R5 R6 read waits");
    bus_cycle(1, 1, 2, 0, "R4 slow write");
    bus_cycle(1, 1, 6, 0, "R5 slow write waits");
    bus_cycle(0, 0, 1, 0, "R8 read early end");
    bus_cycle(1, 1, 1, 0, "R8 slow early end");
    idle_clk("R7 idle after end");
    bus_cycle(1, 0, 3, 1, "R9 write latched");
    bus_cycle(0, 0, 3, 1, "R9 read latched");
    bus_cycle(1, 0, 2, 0, "R10 back-to-back");
    bus_cycle(0, 0, 3, 0, "R10 back-to-back");
    idle_clk("R7 idle");
    idle_clk("R7 idle");
    // reset mid read cycle
    @(negedge clk);
    ads = 1; cs = 1; wr = 0; slow = 0; rdata = $urandom;
    push(0, 0, "R1 pre");
    @(negedge clk);
    ads = 0; cs = 0; rdata = $urandom;
    push(0, 1, "R6 before reset");
    @(negedge clk);
    rst_ni = 0;
    #1;
    checks++;
    if (rdy_out !== 0 || oe !== 0 || dout !== '0) begin
      errors++;
      $display("FAIL R1 mid reset: rdy=%b oe=%b dout=%h expected 0 0 0", rdy_out, oe, dout);
    end
    @(negedge clk);
    rst_ni = 1;
    idle_clk("R1 after reset");
    bus_cycle(0, 0, 2, 0, "R4 after reset");
    idle_clk("R7 final");
    @(negedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule